// File: doc/BRIEF.md
# Stereo Line Output Router

This block sits on a digital audio path and decides what reaches the left and right line outputs for each stereo sample. On every sample strobe it takes one signed left sample, one signed right sample and a 3-bit mode code. One cycle later it presents a registered pair of output samples with a one-cycle valid flag.

Five modes are defined:

- plain stereo pass-through;
- left-only mono on both outputs;
- right-only mono on both outputs;
- an averaged mono mix;
- a centre-removal mode, which puts half the channel difference on both outputs. Material panned equally to both channels cancels out.

The three remaining codes are reserved and behave as stereo.

The mode code is read only at the sample strobe. A code change between strobes takes effect at the next sample boundary. Between strobes the outputs hold their last values.

Top module: `stereo_line_router`

## Requirements
- R1: After reset, both outputs are zero and the valid flag is low.
- R2: The valid flag is high in exactly the cycle after each cycle in which the sample strobe is high, and low in every other cycle.
- R3: Mode code 3'b000 gives the left input on the left output and the right input on the right output.
- R4: Mode code 3'b001 gives the left input on both outputs.
- R5: Mode code 3'b010 gives the right input on both outputs.
- R6: Mode code 3'b011 gives floor((L+R)/2) on both outputs. The sum is formed one bit wider than the inputs, so extreme inputs never wrap.
- R7: Mode code 3'b100 gives floor((L-R)/2) on both outputs. The difference is formed one bit wider than the inputs, and equal inputs give zero.
- R8: Mode codes 3'b101, 3'b110 and 3'b111 behave exactly like 3'b000.
- R9: In cycles without a strobe, the outputs keep their values. Changes to the sample or mode inputs do not affect them until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | One-cycle pulse marking a new stereo sample |
| leftIn | input | W | Signed left sample (two's complement) |
| rightIn | input | W | Signed right sample (two's complement) |
| modeSel | input | 3 | Line mode code, read at the strobe |
| leftOut | output | W | Registered signed left output |
| rightOut | output | W | Registered signed right output |
| outValid | output | 1 | High for one cycle when a new output pair is presented |

## Verification
The assertions check on every cycle that:

- the valid flag follows the strobe by exactly one cycle;
- the outputs hold between strobes;
- the mono and mix modes give identical left and right outputs;
- stereo mode passes both samples through;
- centre removal gives zero for equal inputs.

The actual arithmetic of the averaged mix and of the difference path only shows up in the bench's sweep. This covers floor rounding of odd sums and differences, and freedom from wrap at the most negative and most positive inputs. The sweep also covers the reserved codes and mode changes made between strobes.

// File: rtl/line_router_pkg.sv
package line_router_pkg;

  typedef enum logic [2:0] {
    MODE_STEREO  = 3'b000,
    MODE_LEFT    = 3'b001,
    MODE_RIGHT   = 3'b010,
    MODE_MIX     = 3'b011,
    MODE_CENTRE  = 3'b100
  } lineMode_e;

  typedef enum logic [1:0] {
    SRC_LEFT  = 2'd0,
    SRC_RIGHT = 2'd1,
    SRC_SUM   = 2'd2,
    SRC_DIFF  = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic    load;
    srcSel_e leftSrc;
    srcSel_e rightSrc;
  } routeCtl_t;

endpackage

// File: rtl/line_router_ctrl.sv
module line_router_ctrl
  import line_router_pkg::*;
(
  input  logic       sampleStrobe,
  input  logic [2:0] modeSel,
  output routeCtl_t  ctl
);

  always_comb begin
    ctl.load     = sampleStrobe;
    ctl.leftSrc  = SRC_LEFT;
    ctl.rightSrc = SRC_RIGHT;
    case (modeSel)
      MODE_LEFT: begin
        ctl.leftSrc  = SRC_LEFT;
        ctl.rightSrc = SRC_LEFT;
      end
      MODE_RIGHT: begin
        ctl.leftSrc  = SRC_RIGHT;
        ctl.rightSrc = SRC_RIGHT;
      end
      MODE_MIX: begin
        ctl.leftSrc  = SRC_SUM;
        ctl.rightSrc = SRC_SUM;
      end
      MODE_CENTRE: begin
        ctl.leftSrc  = SRC_DIFF;
        ctl.rightSrc = SRC_DIFF;
      end
      default: begin
        // stereo and all reserved codes
        ctl.leftSrc  = SRC_LEFT;
        ctl.rightSrc = SRC_RIGHT;
      end
    endcase
  end

endmodule

// File: rtl/line_router_dp.sv
module line_router_dp
  import line_router_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  routeCtl_t    ctl,
  input  logic [W-1:0] leftIn,
  input  logic [W-1:0] rightIn,
  output logic [W-1:0] leftOut,
  output logic [W-1:0] rightOut,
  output logic         outValid
);

  localparam int WIDE = W + 1;

  logic [WIDE-1:0] leftWide;
  logic [WIDE-1:0] rightWide;
  logic [WIDE-1:0] sumWide;
  logic [WIDE-1:0] diffWide;
  logic [W-1:0]    sumHalf;
  logic [W-1:0]    diffHalf;
  logic [W-1:0]    chanNext [2];

  assign leftWide  = {leftIn[W-1], leftIn};
  assign rightWide = {rightIn[W-1], rightIn};
  assign sumWide   = leftWide + rightWide;
  assign diffWide  = leftWide - rightWide;
  // dropping the lsb of a wide two's-complement value is a floor halving
  assign sumHalf   = sumWide[WIDE-1:1];
  assign diffHalf  = diffWide[WIDE-1:1];

  function automatic logic [W-1:0] pickSrc(input srcSel_e sel,
                                           input logic [W-1:0] l,
                                           input logic [W-1:0] r,
                                           input logic [W-1:0] s,
                                           input logic [W-1:0] d);
    case (sel)
      SRC_LEFT:  pickSrc = l;
      SRC_RIGHT: pickSrc = r;
      SRC_SUM:   pickSrc = s;
      default:   pickSrc = d;
    endcase
  endfunction

  always_comb begin
    chanNext[0] = pickSrc(ctl.leftSrc,  leftIn, rightIn, sumHalf, diffHalf);
    chanNext[1] = pickSrc(ctl.rightSrc, leftIn, rightIn, sumHalf, diffHalf);
  end

  logic [W-1:0] chanReg [2];

  for (genvar c = 0; c < 2; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanReg[c] <= '0;
      end else if (ctl.load) begin
        chanReg[c] <= chanNext[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.load;
    end
  end

  assign leftOut  = chanReg[0];
  assign rightOut = chanReg[1];

endmodule

// File: rtl/stereo_line_router.sv
module stereo_line_router
  import line_router_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleStrobe,
  input  logic [W-1:0] leftIn,
  input  logic [W-1:0] rightIn,
  input  logic [2:0]   modeSel,
  output logic [W-1:0] leftOut,
  output logic [W-1:0] rightOut,
  output logic         outValid
);

  routeCtl_t ctl;

  line_router_ctrl u_ctrl (
    .sampleStrobe (sampleStrobe),
    .modeSel      (modeSel),
    .ctl          (ctl)
  );

  line_router_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .leftIn   (leftIn),
    .rightIn  (rightIn),
    .leftOut  (leftOut),
    .rightOut (rightOut),
    .outValid (outValid)
  );

endmodule

// File: rtl/line_router_chk.sv
module line_router_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         sampleStrobe,
  input logic [W-1:0] leftIn,
  input logic [W-1:0] rightIn,
  input logic [2:0]   modeSel,
  input logic [W-1:0] leftOut,
  input logic [W-1:0] rightOut,
  input logic         outValid
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (rstN || (leftOut == '0 && rightOut == '0 && !outValid)));

  // R2
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> outValid);

  // R2
  valid_only_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> !outValid);

  // R9
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> ($stable(leftOut) && $stable(rightOut)));

  // R3
  stereo_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && modeSel == 3'b000) |=>
      (leftOut == $past(leftIn) && rightOut == $past(rightIn)));

  // R4 R5 R6 R7
  mono_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && modeSel >= 3'b001 && modeSel <= 3'b100) |=>
      (leftOut == rightOut));

  // R7
  centre_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && modeSel == 3'b100 && leftIn == rightIn) |=>
      (leftOut == '0));

endmodule

bind stereo_line_router line_router_chk #(.W(W)) u_line_router_chk (
  .clk          (clk),
  .rstN         (rstN),
  .sampleStrobe (sampleStrobe),
  .leftIn       (leftIn),
  .rightIn      (rightIn),
  .modeSel      (modeSel),
  .leftOut      (leftOut),
  .rightOut     (rightOut),
  .outValid     (outValid)
);

// File: tb/test_stereo_line_router.sv
module test_stereo_line_router;

  localparam int W    = 5;
  localparam int MINV = -(1 << (W - 1));
  localparam int MAXV = (1 << (W - 1)) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sampleStrobe = 1'b0;
  logic [W-1:0] leftIn = '0;
  logic [W-1:0] rightIn = '0;
  logic [2:0]   modeSel = '0;
  logic [W-1:0] leftOut;
  logic [W-1:0] rightOut;
  logic         outValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stereo_line_router #(.W(W)) i_stereo_line_router (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .leftIn       (leftIn),
    .rightIn      (rightIn),
    .modeSel      (modeSel),
    .leftOut      (leftOut),
    .rightOut     (rightOut),
    .outValid     (outValid)
  );

  function automatic string reqOf(input int m);
    case (m)
      0: reqOf = "R3";
      1: reqOf = "R4";
      2: reqOf = "R5";
      3: reqOf = "R6";
      4: reqOf = "R7";
      default: reqOf = "R8";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int expL;
    int expR;
    int lastL;
    int lastR;
    repeat (3) @(negedge clk);
    // R1
    check("R1", $signed(leftOut), 0);
    check("R1", $signed(rightOut), 0);
    check("R1", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", int'(outValid), 0);
    for (int m = 0; m < 8; m++) begin
      for (int l = MINV; l <= MAXV; l++) begin
        for (int r = MINV; r <= MAXV; r++) begin
          case (m)
            1: begin expL = l; expR = l; end
            2: begin expL = r; expR = r; end
            3: begin expL = (l + r) >>> 1; expR = expL; end
            4: begin expL = (l - r) >>> 1; expR = expL; end
            default: begin expL = l; expR = r; end
          endcase
          leftIn = l[W-1:0];
          rightIn = r[W-1:0];
          modeSel = m[2:0];
          sampleStrobe = 1'b1;
          @(negedge clk);
          sampleStrobe = 1'b0;
          check(reqOf(m), $signed(leftOut), expL);
          check(reqOf(m), $signed(rightOut), expR);
          check("R2", int'(outValid), 1);
          lastL = $signed(leftOut);
          lastR = $signed(rightOut);
          // R9: disturb mode and samples with no strobe
          modeSel = 3'(m + 3);
          leftIn = ~leftIn;
          rightIn = rightIn + 1'b1;
          @(negedge clk);
          check("R9", $signed(leftOut), lastL);
          check("R9", $signed(rightOut), lastR);
          check("R2", int'(outValid), 0);
        end
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule